// File: doc/BRIEF.md
# Dual-View Word/Byte Memory

This block holds one array of bytes and offers it through two views at once. An instruction fetch port takes a byte address (the program counter) and returns one byte. A data port takes a word address, scales it by four to a byte base, and reads or writes a 32-bit word laid out most-significant byte first. A third port lets a test environment preload program bytes one at a time.

Every port checks its address against the array size. An access that would touch a byte past the end is not carried out, and an error pulse is raised instead. The load port also rejects any value that does not fit in eight bits. Read results and error pulses appear one clock after the request. A fetch and a data write may arrive in the same cycle, and both are serviced.

Top module: `dualview_mem`

## Requirements
- R1: While reset is low, and in the first cycle after it, `fetch_valid`, `fetch_err`, `data_valid`, `data_err` and `load_err` are 0, and `fetch_byte` and `mdr_out` are 0.
- R2: A fetch request at byte address A, with A no greater than MEM_BYTES-1, gives `fetch_byte` equal to the stored byte at A and a one-cycle `fetch_valid` pulse on the next clock. With no request, neither `fetch_valid` nor `fetch_err` pulses.
- R3: A data read at word address M uses the byte base B = 4*M. On the next clock, `mdr_out` equals {byte[B], byte[B+1], byte[B+2], byte[B+3]}, with byte[B] in bits 31:24, and `data_valid` pulses. `mdr_out` changes only on a completed read.
- R4: A data write at word address M stores `mdr_in` bits 31:24 at B, 23:16 at B+1, 15:8 at B+2 and 7:0 at B+3. A write raises no `data_valid`.
- R5: A byte that has not been written since reset reads as 0 through both the fetch port and the data port.
- R6: A fetch at A greater than MEM_BYTES-1 raises `fetch_err` on the next clock. It raises no `fetch_valid` and leaves `fetch_byte` unchanged.
- R7: A data access with B+3 greater than MEM_BYTES-1 raises `data_err` on the next clock. It raises no `data_valid`, leaves `mdr_out` unchanged and writes nothing.
- R8: A load writes the low eight bits of `load_value` at `load_addr` only when `load_value` is 255 or less and `load_addr` is in range. Otherwise `load_err` pulses on the next clock and the array is unchanged.
- R9: When a fetch and a data write hit the same byte in the same cycle, the fetch returns the byte's old value. The new value is visible from the next cycle on.
- R10: When a load and a data write target the same byte in the same cycle, the loaded byte is kept. The other bytes of the word take the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the array |
| fetch_req | input | 1 | Fetch request |
| fetch_pc | input | ADDR_W | Fetch byte address |
| fetch_byte | output | 8 | Fetched byte, one cycle after the request |
| fetch_valid | output | 1 | Fetch completed |
| fetch_err | output | 1 | Fetch address out of range |
| data_req | input | 1 | Data port request |
| data_we | input | 1 | 1 = word write, 0 = word read |
| data_mar | input | ADDR_W | Word address, scaled by four internally |
| mdr_in | input | 32 | Word to write |
| mdr_out | output | 32 | Word read, held until the next completed read |
| data_valid | output | 1 | Word read completed |
| data_err | output | 1 | Data access out of range |
| load_en | input | 1 | Preload strobe |
| load_addr | input | ADDR_W | Preload byte address |
| load_value | input | LOAD_W | Preload value, must be 255 or less |
| load_err | output | 1 | Preload rejected |

## Verification
Every result is due exactly one clock after its request: the fetched byte, the read word, the valid pulses and all three error pulses. Writes and loads become visible to a read issued on the following cycle. The bench drives each request on a falling edge, drops it on the next falling edge, and samples the outputs at that same falling edge, half a period after the capturing rising edge. A follow-up read on a later cycle then confirms what each write or rejected access left in the array.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned LANES  = 4;
   localparam int unsigned WORD_W = BYTE_W * LANES;

   typedef logic [BYTE_W-1:0] byte_t;
   // lane 0 is the lowest byte address of a word, i.e. the most significant byte
   typedef byte_t [LANES-1:0] lanes_t;
endpackage

// File: rtl/dvm_range_chk.sv
module dvm_range_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SPAN      = 1,
   parameter int unsigned MEM_BYTES = 64
) (
   input  logic [ADDR_W-1:0] base_addr,
   output logic              in_range
);
   localparam int unsigned     LIMIT   = MEM_BYTES - SPAN;
   localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W+1)'(LIMIT);

   if (SPAN < 1 || SPAN > MEM_BYTES) begin : g_bad_span
      $error("dvm_range_chk: SPAN must lie in 1..MEM_BYTES");
   end
   if (ADDR_W < 32 && 64'(MEM_BYTES) > (64'd1 << ADDR_W)) begin : g_bad_width
      $error("dvm_range_chk: ADDR_W too narrow for MEM_BYTES");
   end

   assign in_range = ({1'b0, base_addr} <= LIMIT_V);
endmodule

// File: rtl/dvm_word_lanes.sv
module dvm_word_lanes
   import dvm_pkg::*;
(
   input  logic [WORD_W-1:0] wr_word,
   output lanes_t            wr_lanes,
   input  lanes_t            rd_lanes,
   output logic [WORD_W-1:0] rd_word
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int unsigned HI = WORD_W - 1 - k * BYTE_W;
      assign wr_lanes[k]            = wr_word[HI -: BYTE_W];
      assign rd_word[HI -: BYTE_W]  = rd_lanes[k];
   end
endmodule

// File: rtl/dvm_byte_store.sv
module dvm_byte_store
   import dvm_pkg::*;
#(
   parameter  int unsigned DEPTH = 4096,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ww_en,
   input  logic [IDX_W-1:0] ww_base,
   input  lanes_t           ww_lanes,
   input  logic             bw_en,
   input  logic [IDX_W-1:0] bw_idx,
   input  byte_t            bw_data,
   input  logic             fr_en,
   input  logic [IDX_W-1:0] fr_idx,
   output byte_t            fr_q,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_base,
   output lanes_t           wr_q
);
   if (DEPTH < LANES) begin : g_bad_depth
      $error("dvm_byte_store: DEPTH must hold at least one word");
   end

   byte_t mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            mem[i] <= '0;
         end
         fr_q <= '0;
         wr_q <= '0;
      end else begin
         // reads see the array before this edge's writes
         if (fr_en) begin
            fr_q <= mem[fr_idx];
         end
         if (wr_en) begin
            for (int k = 0; k < int'(LANES); k++) begin
               wr_q[k] <= mem[wr_base + IDX_W'(k)];
            end
         end
         if (ww_en) begin
            for (int k = 0; k < int'(LANES); k++) begin
               mem[ww_base + IDX_W'(k)] <= ww_lanes[k];
            end
         end
         // preload comes last so it wins on an overlapping byte
         if (bw_en) begin
            mem[bw_idx] <= bw_data;
         end
      end
   end
endmodule

// File: rtl/dualview_mem.sv
module dualview_mem
   import dvm_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 4096,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned LOAD_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic [7:0]        fetch_byte,
   output logic              fetch_valid,
   output logic              fetch_err,
   input  logic              data_req,
   input  logic              data_we,
   input  logic [ADDR_W-1:0] data_mar,
   input  logic [31:0]       mdr_in,
   output logic [31:0]       mdr_out,
   output logic              data_valid,
   output logic              data_err,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [LOAD_W-1:0] load_value,
   output logic              load_err
);
   localparam int unsigned IDX_W = $clog2(MEM_BYTES);
   localparam int unsigned BA_W  = ADDR_W + 2;

   if (MEM_BYTES < LANES) begin : g_bad_size
      $error("dualview_mem: MEM_BYTES must hold at least one word");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("dualview_mem: ADDR_W cannot reach every byte");
   end
   if (LOAD_W < BYTE_W) begin : g_bad_load
      $error("dualview_mem: LOAD_W narrower than a byte");
   end

   logic            f_ok, d_ok, l_ok, l_fits;
   logic [BA_W-1:0] d_base;
   lanes_t          wr_lanes, rd_lanes;
   byte_t           fr_q;

   assign d_base = {data_mar, 2'b00};

   if (LOAD_W > BYTE_W) begin : g_fit_chk
      assign l_fits = ~|load_value[LOAD_W-1:BYTE_W];
   end else begin : g_fit_any
      assign l_fits = 1'b1;
   end

   dvm_range_chk #(.ADDR_W(ADDR_W), .SPAN(1), .MEM_BYTES(MEM_BYTES)) u_fetch_rng (
      .base_addr (fetch_pc),
      .in_range  (f_ok)
   );
   dvm_range_chk #(.ADDR_W(BA_W), .SPAN(LANES), .MEM_BYTES(MEM_BYTES)) u_data_rng (
      .base_addr (d_base),
      .in_range  (d_ok)
   );
   dvm_range_chk #(.ADDR_W(ADDR_W), .SPAN(1), .MEM_BYTES(MEM_BYTES)) u_load_rng (
      .base_addr (load_addr),
      .in_range  (l_ok)
   );

   dvm_word_lanes u_lanes (
      .wr_word  (mdr_in),
      .wr_lanes (wr_lanes),
      .rd_lanes (rd_lanes),
      .rd_word  (mdr_out)
   );

   dvm_byte_store #(.DEPTH(MEM_BYTES)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ww_en    (data_req & data_we & d_ok),
      .ww_base  (d_base[IDX_W-1:0]),
      .ww_lanes (wr_lanes),
      .bw_en    (load_en & l_ok & l_fits),
      .bw_idx   (load_addr[IDX_W-1:0]),
      .bw_data  (load_value[BYTE_W-1:0]),
      .fr_en    (fetch_req & f_ok),
      .fr_idx   (fetch_pc[IDX_W-1:0]),
      .fr_q     (fr_q),
      .wr_en    (data_req & ~data_we & d_ok),
      .wr_base  (d_base[IDX_W-1:0]),
      .wr_q     (rd_lanes)
   );

   assign fetch_byte = fr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_valid <= 1'b0;
         fetch_err   <= 1'b0;
         data_valid  <= 1'b0;
         data_err    <= 1'b0;
         load_err    <= 1'b0;
      end else begin
         fetch_valid <= fetch_req & f_ok;
         fetch_err   <= fetch_req & ~f_ok;
         data_valid  <= data_req & ~data_we & d_ok;
         data_err    <= data_req & ~d_ok;
         load_err    <= load_en & ~(l_ok & l_fits);
      end
   end
endmodule

// File: rtl/dvm_chk.sv
module dvm_chk #(
   parameter int unsigned MEM_BYTES = 4096,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned LOAD_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic [7:0]        fetch_byte,
   input logic              fetch_valid,
   input logic              fetch_err,
   input logic              data_req,
   input logic              data_we,
   input logic [ADDR_W-1:0] data_mar,
   input logic [31:0]       mdr_out,
   input logic              data_valid,
   input logic              data_err,
   input logic              load_en,
   input logic [LOAD_W-1:0] load_value,
   input logic              load_err
);
   logic [ADDR_W+2:0] last_byte;
   logic              pc_inside, word_inside, too_big;

   assign pc_inside   = (64'(fetch_pc) < 64'(MEM_BYTES));
   assign last_byte   = {1'b0, data_mar, 2'b00} + (ADDR_W+3)'(3);
   assign word_inside = (64'(last_byte) < 64'(MEM_BYTES));
   assign too_big     = (64'(load_value) > 64'd255);

   p_fetch_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && pc_inside |=> fetch_valid && !fetch_err);
   p_fetch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req |=> !fetch_valid && !fetch_err);
   p_fetch_oor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !pc_inside |=> fetch_err && !fetch_valid && $stable(fetch_byte));
   p_mdr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> $stable(mdr_out));
   p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_req && data_we |=> !data_valid);
   p_data_oor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_req && !word_inside |=> data_err && !data_valid && $stable(mdr_out));
   p_load_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && too_big |=> load_err);
endmodule

bind dualview_mem dvm_chk #(
   .MEM_BYTES (MEM_BYTES),
   .ADDR_W    (ADDR_W),
   .LOAD_W    (LOAD_W)
) u_dvm_chk (.*);

// File: tb/test_dualview_mem.sv
module test_dualview_mem;
   localparam int CLK_P  = 10;
   localparam int NBYTES = 64;
   localparam int AW     = 8;
   localparam int LW     = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic [7:0]    fetch_byte;
   logic          fetch_valid, fetch_err;
   logic          data_req = 1'b0, data_we = 1'b0;
   logic [AW-1:0] data_mar = '0;
   logic [31:0]   mdr_in = '0;
   logic [31:0]   mdr_out;
   logic          data_valid, data_err;
   logic          load_en = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [LW-1:0] load_value = '0;
   logic          load_err;

   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   logic [7:0] model [NBYTES];

   always #(CLK_P/2) clk = ~clk;

   dualview_mem #(.MEM_BYTES(NBYTES), .ADDR_W(AW), .LOAD_W(LW)) i_dualview_mem (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(input int m);
      return {model[4*m], model[4*m+1], model[4*m+2], model[4*m+3]};
   endfunction

   task automatic fetch_one(input int a, input string req);
      logic [7:0] prev;
      logic       oor;
      oor = (a >= NBYTES);
      @(negedge clk);
      prev = fetch_byte;
      fetch_req = 1'b1; fetch_pc = a[AW-1:0];
      @(negedge clk);
      fetch_req = 1'b0;
      check({req, " fetch_valid"}, 32'(fetch_valid), 32'(!oor));
      check({req, " fetch_err"}, 32'(fetch_err), 32'(oor));
      if (oor) check({req, " fetch_byte held"}, 32'(fetch_byte), 32'(prev));
      else     check({req, " fetch_byte"}, 32'(fetch_byte), 32'(model[a]));
   endtask

   task automatic read_word(input int m, input string req);
      logic [31:0] prev;
      logic        oor;
      oor = (4*m + 3 >= NBYTES);
      @(negedge clk);
      prev = mdr_out;
      data_req = 1'b1; data_we = 1'b0; data_mar = m[AW-1:0];
      @(negedge clk);
      data_req = 1'b0;
      check({req, " data_valid"}, 32'(data_valid), 32'(!oor));
      check({req, " data_err"}, 32'(data_err), 32'(oor));
      if (oor) check({req, " mdr_out held"}, mdr_out, prev);
      else     check({req, " mdr_out"}, mdr_out, word_of(m));
   endtask

   task automatic write_word(input int m, input logic [31:0] v, input string req);
      logic oor;
      oor = (4*m + 3 >= NBYTES);
      @(negedge clk);
      data_req = 1'b1; data_we = 1'b1; data_mar = m[AW-1:0]; mdr_in = v;
      @(negedge clk);
      data_req = 1'b0; data_we = 1'b0;
      check({req, " no data_valid on write"}, 32'(data_valid), 32'd0);
      check({req, " data_err"}, 32'(data_err), 32'(oor));
      if (!oor) for (int k = 0; k < 4; k++) model[4*m+k] = v[31-8*k -: 8];
   endtask

   task automatic load_one(input int a, input int v, input string req);
      logic bad;
      bad = (a >= NBYTES) || (v > 255);
      @(negedge clk);
      load_en = 1'b1; load_addr = a[AW-1:0]; load_value = v[LW-1:0];
      @(negedge clk);
      load_en = 1'b0;
      check({req, " load_err"}, 32'(load_err), 32'(bad));
      if (!bad) model[a] = v[7:0];
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NBYTES; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      check("R1 fetch_valid in reset", 32'(fetch_valid), 0);
      check("R1 data_valid in reset", 32'(data_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 fetch_err", 32'(fetch_err), 0);
      check("R1 data_err", 32'(data_err), 0);
      check("R1 load_err", 32'(load_err), 0);
      check("R1 fetch_byte", 32'(fetch_byte), 0);
      check("R1 mdr_out", mdr_out, 0);

      // R5: untouched array reads zero on both views
      for (int a = 0; a < NBYTES; a++) fetch_one(a, "R5 R2 blank");
      for (int m = 0; m < NBYTES/4; m++) read_word(m, "R5 R3 blank");

      // R8: preload every byte with an arithmetic pattern
      for (int a = 0; a < NBYTES; a++) load_one(a, (a*37 + 11) % 256, "R8 preload");
      for (int a = 0; a < NBYTES; a++) fetch_one(a, "R2 after preload");
      for (int m = 0; m < NBYTES/4; m++) read_word(m, "R3 after preload");

      // R4: word writes laid out big-endian
      for (int m = 0; m < NBYTES/4; m += 2)
         write_word(m, (32'h01020304 * 32'(m + 1)) ^ 32'hF0E1D2C3, "R4 write");
      for (int a = 0; a < NBYTES; a++) fetch_one(a, "R4 byte view");
      for (int m = 0; m < NBYTES/4; m++) read_word(m, "R4 R3 word view");

      // R6: fetch past the end
      fetch_one(NBYTES - 1, "R6 last byte");
      fetch_one(NBYTES, "R6 one past");
      fetch_one(NBYTES + 5, "R6 beyond");
      fetch_one(255, "R6 top");

      // R7: data accesses past the end
      read_word(NBYTES/4 - 1, "R7 last word");
      read_word(NBYTES/4, "R7 read one past");
      read_word(255, "R7 read top");
      write_word(NBYTES/4, 32'hCAFEF00D, "R7 write one past");
      read_word(NBYTES/4 - 1, "R7 last word untouched");
      fetch_one(NBYTES - 1, "R7 last byte untouched");

      // R8: rejected loads leave the array alone
      load_one(5, 256, "R8 value 256");
      fetch_one(5, "R8 byte 5 unchanged");
      load_one(NBYTES, 1, "R8 addr past end");
      load_one(6, 255, "R8 value 255");
      fetch_one(6, "R8 byte 6 loaded");

      // R9: fetch and write on the same byte in one cycle
      @(negedge clk);
      data_req = 1'b1; data_we = 1'b1; data_mar = 8'd3; mdr_in = 32'hDEADBEEF;
      fetch_req = 1'b1; fetch_pc = 8'd13;
      @(negedge clk);
      data_req = 1'b0; data_we = 1'b0; fetch_req = 1'b0;
      check("R9 fetch_valid", 32'(fetch_valid), 1);
      check("R9 old byte", 32'(fetch_byte), 32'(model[13]));
      model[12] = 8'hDE; model[13] = 8'hAD; model[14] = 8'hBE; model[15] = 8'hEF;
      fetch_one(13, "R9 new byte");
      read_word(3, "R9 new word");

      // R10: load and data write on the same byte in one cycle
      @(negedge clk);
      load_en = 1'b1; load_addr = 8'd20; load_value = 16'h005A;
      data_req = 1'b1; data_we = 1'b1; data_mar = 8'd5; mdr_in = 32'h11223344;
      @(negedge clk);
      load_en = 1'b0; data_req = 1'b0; data_we = 1'b0;
      check("R10 load_err", 32'(load_err), 0);
      model[20] = 8'h5A; model[21] = 8'h22; model[22] = 8'h33; model[23] = 8'h44;
      read_word(5, "R10 merged word");
      check("R10 merged value", mdr_out, 32'h5A223344);

      // R3: mdr_out holds across idle cycles and fetches
      repeat (3) @(negedge clk);
      check("R3 mdr_out held idle", mdr_out, 32'h5A223344);
      fetch_one(2, "R3 fetch between reads");
      check("R3 mdr_out held over fetch", mdr_out, 32'h5A223344);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule